// File: doc/BRIEF.md
# Fractional Baud-Rate Generator

This block produces the bit timing for a 16550-style serial port from a fixed reference clock, nominally 20 MHz. The reference runs through three stages in series. The first is an integer prescaler whose ratio is chosen by a 3-bit code. The second is a fractional x/y rate multiplier built as a phase accumulator. The third is a 16-bit integer divisor. The outputs are a one-cycle 16x oversampling tick and a one-cycle bit-rate tick that fires on every sixteenth oversampling tick.

A small word-addressed write/read port holds the settings: the two divisor bytes, the prescaler code and a packed fraction word. The divisor bytes can only be reached while the line-control divisor-access bit (`dlab`) is high. Every accepted configuration write restarts all stages from zero, so the new rate begins cleanly. The oversampling rate is reference / ratio × (x / y) / divisor.

Top module: `baud_frac_gen`

## Requirements
- R1: After reset, the prescaler code reads 4, the divisor reads 1 and the fraction word reads 0. No tick is produced until the block is configured.
- R2: Prescaler codes 0 through 7 divide the reference by 1, 2, 4, 8, 10, 12, 16 and 20 respectively. Counted from a configuration write, the first prescaled enable falls in the cycle with index ratio−1, and one follows every ratio cycles after that.
- R3: The fraction word holds x in bits 31:16 and y in bits 15:0. After P prescaled enables counted from a configuration write, the accumulator has passed exactly floor(P·x/y) pulses to the divisor stage.
- R4: With divisor D ≥ 1, the oversampling tick fires once for every D accumulator pulses, and never on two consecutive cycles when D ≥ 2. With D = 0 it never fires.
- R5: A fraction with x = 0, or with x ≥ y, produces no oversampling ticks.
- R6: The bit tick is high only in a cycle where the oversampling tick is also high, and it fires on every sixteenth oversampling tick counted from the last configuration write.
- R7: The register map uses these word addresses: 0 is the divisor low byte, 1 is the divisor high byte, 10 is the prescaler code in bits 2:0, and 11 is the fraction word. All register bits read back as written. Any other address reads 0.
- R8: When `dlab` is 0, a write to address 0 or 1 is ignored, and reads of address 0 or 1 return 0.
- R9: An accepted write to the divisor, the prescaler code or the fraction clears the prescaler, the accumulator, the divisor counter and the bit counter. Both ticks are low in the cycle after the write.
- R10: With divisor 1, y = 65000 and prescaler codes 4, 2 or 1, the numerator setting for each standard rate from 110 to 460800 baud produces the tick count that the rate formula predicts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| dlab | input | 1 | Divisor-access bit taken from the line-control register |
| reg_rdata | output | 32 | Register read data, combinational from the address |
| tick16_o | output | 1 | 16x oversampling tick, one cycle wide |
| bit_tick_o | output | 1 | Bit-rate tick, one cycle wide |

## Verification
The three-stage chain is driven with standard-rate settings at the slowest, middle and fastest rates, and with a sweep of all eight prescaler codes. It is also driven with random numerators, denominators, codes and small divisors. Each tick count is compared with a closed form: floor(floor(N/ratio)·x/y / D). This shows whether an error lies in the prescaler ratio, in the accumulator's pulse removal or in the divisor wrap. Directed cases with a zero divisor, a zero numerator, and a numerator equal to or above the denominator separate the gating of the stages from normal counting. Divisor writes made while `dlab` is low separate the ignored writes from the accepted ones.

// File: rtl/baud_pkg.sv
package baud_pkg;
    localparam int PS_CODE_W = 3;
    localparam int PS_CNT_W  = 5;

    localparam int ADR_DIV_LO = 0;
    localparam int ADR_DIV_HI = 1;
    localparam int ADR_PSCODE = 10;
    localparam int ADR_FRAC   = 11;

    function automatic logic [PS_CNT_W-1:0] ps_ratio(input logic [PS_CODE_W-1:0] code);
        logic [PS_CNT_W-1:0] r;
        case (code)
            3'd0:    r = 5'd1;
            3'd1:    r = 5'd2;
            3'd2:    r = 5'd4;
            3'd3:    r = 5'd8;
            3'd4:    r = 5'd10;
            3'd5:    r = 5'd12;
            3'd6:    r = 5'd16;
            default: r = 5'd20;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/baud_cfg_regs.sv
module baud_cfg_regs
    import baud_pkg::*;
#(
    parameter int DIV_W   = 16,
    parameter int FRAC_W  = 16,
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32,
    parameter int DIV_RST = 1,
    parameter int PS_RST  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    input  logic                 dlab,
    output logic [DATA_W-1:0]    rdata,
    output logic                 cfg_wr,
    output logic [DIV_W-1:0]     div_val,
    output logic [PS_CODE_W-1:0] ps_code,
    output logic [FRAC_W-1:0]    frac_x,
    output logic [FRAC_W-1:0]    frac_y
);
    localparam int HI_W = DIV_W - 8;

    typedef struct packed {
        logic [DIV_W-1:0]     div;
        logic [PS_CODE_W-1:0] code;
        logic [2*FRAC_W-1:0]  frac;
    } cfg_t;

    cfg_t st_d, st_q;

    logic hit_lo, hit_hi, hit_ps, hit_fr;

    always_comb begin
        hit_lo = (addr == ADDR_W'(ADR_DIV_LO)) && dlab;
        hit_hi = (addr == ADDR_W'(ADR_DIV_HI)) && dlab;
        hit_ps = (addr == ADDR_W'(ADR_PSCODE));
        hit_fr = (addr == ADDR_W'(ADR_FRAC));
        cfg_wr = wr_en && (hit_lo || hit_hi || hit_ps || hit_fr);

        st_d = st_q;
        if (wr_en && hit_lo) st_d.div[7:0]       = wdata[7:0];
        if (wr_en && hit_hi) st_d.div[DIV_W-1:8] = wdata[HI_W-1:0];
        if (wr_en && hit_ps) st_d.code           = wdata[PS_CODE_W-1:0];
        if (wr_en && hit_fr) st_d.frac           = wdata[2*FRAC_W-1:0];

        rdata = '0;
        if (hit_lo)      rdata = {{(DATA_W-8){1'b0}}, st_q.div[7:0]};
        else if (hit_hi) rdata = {{(DATA_W-HI_W){1'b0}}, st_q.div[DIV_W-1:8]};
        else if (hit_ps) rdata = {{(DATA_W-PS_CODE_W){1'b0}}, st_q.code};
        else if (hit_fr) rdata = DATA_W'(st_q.frac);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.div  <= DIV_W'(DIV_RST);
            st_q.code <= PS_CODE_W'(PS_RST);
            st_q.frac <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign div_val = st_q.div;
    assign ps_code = st_q.code;
    assign frac_x  = st_q.frac[2*FRAC_W-1:FRAC_W];
    assign frac_y  = st_q.frac[FRAC_W-1:0];
endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler
    import baud_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic [PS_CODE_W-1:0] code,
    output logic                 en_o
);
    typedef struct packed {
        logic [PS_CNT_W-1:0] cnt;
    } ps_t;

    ps_t st_d, st_q;
    logic [PS_CNT_W-1:0] last;

    always_comb begin
        last = ps_ratio(code) - PS_CNT_W'(1);
        en_o = !clr && (st_q.cnt == last);
        st_d = st_q;
        if (clr || en_o) st_d.cnt = '0;
        else             st_d.cnt = st_q.cnt + PS_CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/baud_frac_acc.sv
module baud_frac_acc #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step_en,
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic         pulse_o
);
    typedef struct packed {
        logic [W:0] acc;
    } acc_t;

    acc_t st_d, st_q;
    logic [W:0] sum;
    logic       usable;

    always_comb begin
        usable  = (x != '0) && (x < y);
        sum     = st_q.acc + {1'b0, x};
        pulse_o = !clr && step_en && usable && (sum >= {1'b0, y});
        st_d    = st_q;
        if (clr) begin
            st_d.acc = '0;
        end else if (step_en && usable) begin
            if (pulse_o) st_d.acc = sum - {1'b0, y};
            else         st_d.acc = sum;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/baud_div_count.sv
module baud_div_count #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step_en,
    input  logic [W-1:0] div,
    output logic         tick_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } dc_t;

    dc_t st_d, st_q;

    always_comb begin
        tick_o = !clr && step_en && (div != '0) && (st_q.cnt == div - W'(1));
        st_d   = st_q;
        if (clr)                         st_d.cnt = '0;
        else if (tick_o)                 st_d.cnt = '0;
        else if (step_en && div != '0)   st_d.cnt = st_q.cnt + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/baud_frac_gen.sv
module baud_frac_gen
    import baud_pkg::*;
#(
    parameter int DIV_W      = 16,
    parameter int FRAC_W     = 16,
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 32,
    parameter int OVERSAMPLE = 16,
    parameter int DIV_RST    = 1,
    parameter int PS_RST     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              dlab,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              tick16_o,
    output logic              bit_tick_o
);
    localparam int OVS_W = $clog2(OVERSAMPLE);

    logic                 cfg_wr;
    logic [DIV_W-1:0]     div_val;
    logic [PS_CODE_W-1:0] ps_code;
    logic [FRAC_W-1:0]    frac_x, frac_y;
    logic                 ps_en, fr_pulse, div_tick;

    baud_cfg_regs #(
        .DIV_W(DIV_W), .FRAC_W(FRAC_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .DIV_RST(DIV_RST), .PS_RST(PS_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .dlab(dlab), .rdata(reg_rdata), .cfg_wr(cfg_wr),
        .div_val(div_val), .ps_code(ps_code), .frac_x(frac_x), .frac_y(frac_y)
    );

    baud_prescaler u_ps (
        .clk(clk), .rst_n(rst_n), .clr(cfg_wr), .code(ps_code), .en_o(ps_en)
    );

    baud_frac_acc #(.W(FRAC_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .clr(cfg_wr), .step_en(ps_en),
        .x(frac_x), .y(frac_y), .pulse_o(fr_pulse)
    );

    baud_div_count #(.W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .clr(cfg_wr), .step_en(fr_pulse),
        .div(div_val), .tick_o(div_tick)
    );

    typedef struct packed {
        logic [OVS_W-1:0] sub;
        logic             tick;
        logic             bit_t;
    } out_t;

    out_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_wr) begin
            st_d = '0;
        end else begin
            st_d.tick  = div_tick;
            st_d.bit_t = div_tick && (st_q.sub == OVS_W'(OVERSAMPLE - 1));
            if (div_tick) st_d.sub = st_q.sub + OVS_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick16_o   = st_q.tick;
    assign bit_tick_o = st_q.bit_t;
endmodule

// File: rtl/baud_frac_chk.sv
module baud_frac_chk #(
    parameter int DIV_W  = 16,
    parameter int FRAC_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr,
    input logic [DIV_W-1:0]  div_val,
    input logic [FRAC_W-1:0] frac_x,
    input logic [FRAC_W-1:0] frac_y,
    input logic              tick16_o,
    input logic              bit_tick_o
);
    assert_bit_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick_o |-> tick16_o);

    assert_bit_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick_o |=> !bit_tick_o);

    assert_quiet_after_cfg_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (!tick16_o && !bit_tick_o));

    assert_div_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (div_val == '0) |=> !tick16_o);

    assert_tick_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick16_o && div_val > DIV_W'(1)) |=> !tick16_o);

    assert_bad_frac_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (frac_x == '0 || frac_x >= frac_y) |=> !tick16_o);
endmodule

bind baud_frac_gen baud_frac_chk #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .div_val(div_val),
    .frac_x(frac_x), .frac_y(frac_y), .tick16_o(tick16_o), .bit_tick_o(bit_tick_o)
);

// File: tb/sim_baud_frac_gen.sv
module sim_baud_frac_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        dlab = 1'b0;
    logic [31:0] reg_rdata;
    logic        tick16_o, bit_tick_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    baud_frac_gen u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .dlab(dlab), .reg_rdata(reg_rdata),
        .tick16_o(tick16_o), .bit_tick_o(bit_tick_o)
    );

    function automatic longint ratio_of(input int code);
        case (code)
            0: return 1;  1: return 2;  2: return 4;  3: return 8;
            4: return 10; 5: return 12; 6: return 16; default: return 20;
        endcase
    endfunction

    function automatic longint exp_ticks(input int n, input int code,
                                         input longint x, input longint y, input longint d);
        longint p, f;
        if (x == 0 || x >= y || d == 0) return 0;
        p = n / ratio_of(code);
        f = (p * x) / y;
        return f / d;
    endfunction

    function automatic longint std_x(input longint baud, input int code);
        longint denom;
        denom = 500000 / ratio_of(code);
        return ((baud * 1625) / denom) << 4;
    endfunction

    task automatic check(input string req, input string what, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int a, input logic dl, output logic [31:0] d);
        @(negedge clk);
        reg_addr = 4'(a); dlab = dl;
        #1 d = reg_rdata;
    endtask

    task automatic count_window(input int n, output longint t, output longint b, output longint orphan);
        t = 0; b = 0; orphan = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (tick16_o) t++;
            if (bit_tick_o) b++;
            if (bit_tick_o && !tick16_o) orphan++;
        end
    endtask

    task automatic measure(input string req, input int code, input longint x,
                           input longint y, input longint d, input int n);
        longint t, b, o, et;
        dlab = 1'b1;
        wr(0, 32'(d & 255));
        wr(1, 32'((d >> 8) & 255));
        dlab = 1'b0;
        wr(10, 32'(code));
        wr(11, 32'((x << 16) | y));
        check("R9", "tick low after config write", longint'(tick16_o), 0);
        count_window(n, t, b, o);
        et = exp_ticks(n, code, x, y, d);
        check(req, "oversample tick count", t, et);
        check("R6", "bit tick count", b, et / 16);
        check("R6", "bit tick without oversample tick", o, 0);
    endtask

    initial begin
        logic [31:0] d;
        longint t, b, o;
        void'($urandom(32'd20240511));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        rd(10, 1'b0, d); check("R1", "reset prescaler code", d, 4);
        rd(0, 1'b1, d);  check("R1", "reset divisor low", d, 1);
        rd(1, 1'b1, d);  check("R1", "reset divisor high", d, 0);
        rd(11, 1'b0, d); check("R1", "reset fraction", d, 0);
        count_window(300, t, b, o);
        check("R1", "ticks after reset", t, 0);

        wr(11, 32'h1234_ABCD);
        rd(11, 1'b0, d); check("R7", "fraction readback", d, 32'h1234_ABCD);
        wr(10, 32'hFFFF_FFF6);
        rd(10, 1'b0, d); check("R7", "prescaler code readback", d, 6);
        rd(5, 1'b1, d);  check("R7", "unmapped address", d, 0);

        dlab = 1'b1; wr(0, 32'h0000_0037); wr(1, 32'h0000_00A2);
        dlab = 1'b0; wr(0, 32'h0000_0055); wr(1, 32'h0000_0066);
        rd(0, 1'b1, d); check("R8", "divisor low kept", d, 32'h37);
        rd(1, 1'b1, d); check("R8", "divisor high kept", d, 32'hA2);
        rd(0, 1'b0, d); check("R8", "divisor low hidden", d, 0);
        rd(1, 1'b0, d); check("R8", "divisor high hidden", d, 0);
        dlab = 1'b0;

        measure("R10", 4, std_x(110, 4),    65000, 1, 20000);
        measure("R10", 4, std_x(9600, 4),   65000, 1, 4000);
        measure("R10", 4, std_x(115200, 4), 65000, 1, 20000);
        measure("R10", 2, std_x(230400, 2), 65000, 1, 5000);
        measure("R10", 1, std_x(460800, 1), 65000, 1, 5000);

        for (int c = 0; c < 8; c++) measure("R2", c, 3, 4, 1, 400);

        measure("R3", 0, 7, 13, 1, 1000);
        measure("R4", 0, 1, 2, 3, 1200);
        measure("R4", 1, 5, 6, 0, 800);
        measure("R5", 0, 0, 100, 1, 500);
        measure("R5", 0, 100, 100, 1, 500);
        measure("R5", 0, 40000, 300, 1, 500);

        for (int k = 0; k < 24; k++) begin
            longint y, x, dd;
            int c;
            y  = 2 + longint'($urandom % 65534);
            x  = 1 + longint'($urandom % 32'(y - 1));
            c  = int'($urandom % 8);
            dd = 1 + longint'($urandom % 4);
            measure("R3", c, x, y, dd, 1500);
        end

        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule